// File: doc/BRIEF.md
# Braid Dispatch Distributor

This block sits after the allocate/rename stage and steers groups of compiler-formed instruction braids onto a pool of braid execution units. Each cycle it is offered a group of up to `LANES` decoded instructions, each with a flag that marks the first instruction of a braid. It hands a whole braid to one unit and keeps every later instruction of that braid on the same unit. A unit receives a new braid only while it holds none. Selection looks only at the start flag and at unit idleness. No run-time dependence analysis takes place.

The block reports how many lanes of the offered group it consumed. The upstream stage drops those lanes and presents the remainder from lane 0 in the next cycle. The consumed count is zero when the block stalls. It stalls when no suitable unit is idle, or when the target unit's queue has no room left. At most one braid is opened per cycle.

An exception input funnels all work onto one fixed unit, which gives strict in-order execution. A flush input drops the open braid and marks every unit idle, for checkpoint recovery.

Top module: `braid_distributor`

## Requirements
- R1: After reset no unit is busy and no braid is open. With no valid input, `pushValid` is 0 and `inTaken` is 0.
- R2: In normal mode, an instruction at lane 0 that opens a braid goes to the lowest-numbered idle unit, with `pushStart` = 1. A unit is idle when it is not busy and does not hold the open braid.
- R3: An instruction whose start flag (`inStart[i]` for lane i) is 0 goes to the unit holding the open braid, with `pushStart` = 0.
- R4: A start flag at lane i > 0 ends the take at i lanes, so only one braid is opened per cycle. Lanes at or beyond `inCount` are never taken.
- R5: The number of lanes taken never exceeds the target unit's reported free space, `qSpace[u*SPACE_W +: SPACE_W]`. With zero space nothing is taken.
- R6: If a braid start finds no eligible idle unit, nothing is taken that cycle.
- R7: A unit becomes busy when it is given a braid. It becomes eligible again two cycles after a one-cycle `unitDone[u]` pulse: the pulse is registered, and the busy state clears on the following edge.
- R8: With `excMode` = 1, braids are opened only on unit `EXC_UNIT`. A braid open on any other unit is closed, and the next instruction opens a new braid on `EXC_UNIT`. If that unit is not idle, the block stalls.
- R9: While `flush` = 1 nothing is taken and pending done pulses are discarded. After it, all units are idle and no braid is open.
- R10: An instruction with start flag 0 that arrives when no braid is open opens a new braid as if its flag were set.
- R11: `pushValid` (bit u = unit u) is one-hot or zero, and `pushCount` equals `inTaken`. `pushData` lane i (`[i*DATA_W +: DATA_W]`) carries input lane i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Cancel the open braid and idle all units |
| excMode | input | 1 | Route all work to unit EXC_UNIT |
| inValid | input | 1 | Offered group is valid |
| inCount | input | CNT_W | Number of valid lanes, starting at lane 0 |
| inStart | input | LANES | Per-lane braid start flag |
| inData | input | LANES*DATA_W | Per-lane instruction payload |
| inTaken | output | CNT_W | Lanes consumed this cycle |
| qSpace | input | NUM_UNITS*SPACE_W | Free queue entries of each unit |
| unitDone | input | NUM_UNITS | One-cycle pulse when a unit finishes its braid |
| pushValid | output | NUM_UNITS | One-hot select of the unit receiving lanes |
| pushStart | output | 1 | Pushed lanes open a new braid |
| pushCount | output | CNT_W | Number of lanes pushed, from lane 0 |
| pushData | output | LANES*DATA_W | Lane payloads for the selected unit |

## Verification
The assertions assume that `inCount` never exceeds `LANES`. They also assume that a unit reports free space truthfully and raises `unitDone` only as a single-cycle pulse. The bench keeps `inCount` in the range 1 to `LANES` and `qSpace` in the range 0 to the queue depth. It raises done pulses mostly for units its model believes busy, with rare spurious ones, which the design must tolerate. Mode switches are paired with a flush, and random flushes occur during the sweep.

// File: rtl/braid_dist_pkg.sv
package braid_dist_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;
    logic openStart;
  } ctrl_strb_t;

  // strobes from datapath back to control
  typedef struct packed {
    logic claim;
  } dp_strb_t;

endpackage

// File: rtl/braid_dist_ctrl.sv
module braid_dist_ctrl
  import braid_dist_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int EXC_UNIT  = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flush,
  input  logic                 excMode,
  input  logic                 startLane0,
  input  logic [NUM_UNITS-1:0] unitDone,
  input  dp_strb_t             dpStrb,
  input  logic [NUM_UNITS-1:0] claimHot,
  output ctrl_strb_t           ctrlStrb,
  output logic [NUM_UNITS-1:0] curHot,
  output logic [NUM_UNITS-1:0] allowed
);

  localparam logic [NUM_UNITS-1:0] EXC_HOT = NUM_UNITS'(1) << EXC_UNIT;

  logic                 openQ;
  logic [NUM_UNITS-1:0] curHotQ;
  logic [NUM_UNITS-1:0] busyQ;
  logic [NUM_UNITS-1:0] doneQ;
  logic [NUM_UNITS-1:0] idle;

  always_comb begin
    idle = ~busyQ & ~(openQ ? curHotQ : '0);
    allowed = excMode ? (idle & EXC_HOT) : idle;
    ctrlStrb.flush = flush;
    ctrlStrb.openStart = startLane0 | ~openQ | (excMode & (curHotQ != EXC_HOT));
    curHot = curHotQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      openQ   <= 1'b0;
      curHotQ <= '0;
      busyQ   <= '0;
      doneQ   <= '0;
    end else begin
      doneQ <= unitDone;
      busyQ <= (busyQ & ~doneQ) | (dpStrb.claim ? claimHot : '0);
      if (dpStrb.claim) begin
        openQ   <= 1'b1;
        curHotQ <= claimHot;
      end
    end
  end

endmodule

// File: rtl/braid_dist_datapath.sv
module braid_dist_datapath
  import braid_dist_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int LANES     = 4,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 3,
  parameter int SPACE_W   = 6
) (
  input  logic                         inValid,
  input  logic [CNT_W-1:0]             inCount,
  input  logic [LANES-1:0]             inStart,
  input  logic [LANES*DATA_W-1:0]      inData,
  input  logic [NUM_UNITS*SPACE_W-1:0] qSpace,
  input  ctrl_strb_t                   ctrlStrb,
  input  logic [NUM_UNITS-1:0]         curHot,
  input  logic [NUM_UNITS-1:0]         allowed,
  output dp_strb_t                     dpStrb,
  output logic [NUM_UNITS-1:0]         claimHot,
  output logic [CNT_W-1:0]             inTaken,
  output logic [NUM_UNITS-1:0]         pushValid,
  output logic                         pushStart,
  output logic [CNT_W-1:0]             pushCount,
  output logic [LANES*DATA_W-1:0]      pushData
);

  localparam int MW = (CNT_W > SPACE_W) ? CNT_W : SPACE_W;

  logic [CNT_W-1:0]     runLen;
  logic                 stopRun;
  logic [NUM_UNITS-1:0] pickHot;
  logic [NUM_UNITS-1:0] targetHot;
  logic [SPACE_W-1:0]   tSpace;
  logic [MW-1:0]        runW;
  logic [MW-1:0]        spW;
  logic [MW-1:0]        takeW;
  logic                 go;

  // contiguous lanes from lane 0 up to the next start flag
  always_comb begin
    runLen  = '0;
    stopRun = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (!stopRun) begin
        if ((CNT_W'(i) < inCount) && ((i == 0) || !inStart[i])) runLen = CNT_W'(i + 1);
        else stopRun = 1'b1;
      end
    end
  end

  // lowest eligible unit and its free space
  always_comb begin
    pickHot   = allowed & (~allowed + NUM_UNITS'(1));
    targetHot = ctrlStrb.openStart ? pickHot : curHot;
    tSpace    = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (targetHot[u]) tSpace = tSpace | qSpace[u*SPACE_W +: SPACE_W];
    end
  end

  always_comb begin
    runW  = MW'(runLen);
    spW   = MW'(tSpace);
    takeW = (runW < spW) ? runW : spW;
    go    = !ctrlStrb.flush && inValid && (|targetHot) && (takeW != '0);
    inTaken      = go ? CNT_W'(takeW) : '0;
    pushCount    = inTaken;
    pushValid    = go ? targetHot : '0;
    pushStart    = go && ctrlStrb.openStart;
    dpStrb.claim = go && ctrlStrb.openStart;
    claimHot     = targetHot;
    pushData     = inData;
  end

endmodule

// File: rtl/braid_distributor.sv
module braid_distributor
  import braid_dist_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int LANES     = 4,
  parameter int QDEPTH    = 32,
  parameter int DATA_W    = 32,
  parameter int EXC_UNIT  = 0,
  localparam int CNT_W    = $clog2(LANES + 1),
  localparam int SPACE_W  = $clog2(QDEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         flush,
  input  logic                         excMode,
  input  logic                         inValid,
  input  logic [CNT_W-1:0]             inCount,
  input  logic [LANES-1:0]             inStart,
  input  logic [LANES*DATA_W-1:0]      inData,
  output logic [CNT_W-1:0]             inTaken,
  input  logic [NUM_UNITS*SPACE_W-1:0] qSpace,
  input  logic [NUM_UNITS-1:0]         unitDone,
  output logic [NUM_UNITS-1:0]         pushValid,
  output logic                         pushStart,
  output logic [CNT_W-1:0]             pushCount,
  output logic [LANES*DATA_W-1:0]      pushData
);

  ctrl_strb_t           ctrlStrb;
  dp_strb_t             dpStrb;
  logic [NUM_UNITS-1:0] curHot;
  logic [NUM_UNITS-1:0] allowed;
  logic [NUM_UNITS-1:0] claimHot;

  braid_dist_ctrl #(
    .NUM_UNITS(NUM_UNITS),
    .EXC_UNIT (EXC_UNIT)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .flush     (flush),
    .excMode   (excMode),
    .startLane0(inStart[0]),
    .unitDone  (unitDone),
    .dpStrb    (dpStrb),
    .claimHot  (claimHot),
    .ctrlStrb  (ctrlStrb),
    .curHot    (curHot),
    .allowed   (allowed)
  );

  braid_dist_datapath #(
    .NUM_UNITS(NUM_UNITS),
    .LANES    (LANES),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .SPACE_W  (SPACE_W)
  ) i_dp (
    .inValid  (inValid),
    .inCount  (inCount),
    .inStart  (inStart),
    .inData   (inData),
    .qSpace   (qSpace),
    .ctrlStrb (ctrlStrb),
    .curHot   (curHot),
    .allowed  (allowed),
    .dpStrb   (dpStrb),
    .claimHot (claimHot),
    .inTaken  (inTaken),
    .pushValid(pushValid),
    .pushStart(pushStart),
    .pushCount(pushCount),
    .pushData (pushData)
  );

endmodule

// File: rtl/braid_distributor_chk.sv
module braid_distributor_chk #(
  parameter int NUM_UNITS = 8,
  parameter int LANES     = 4,
  parameter int EXC_UNIT  = 0,
  parameter int CNT_W     = 3,
  parameter int SPACE_W   = 6
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         flush,
  input logic                         excMode,
  input logic                         inValid,
  input logic [CNT_W-1:0]             inCount,
  input logic [CNT_W-1:0]             inTaken,
  input logic [NUM_UNITS*SPACE_W-1:0] qSpace,
  input logic [NUM_UNITS-1:0]         pushValid,
  input logic                         pushStart,
  input logic [CNT_W-1:0]             pushCount
);

  localparam logic [NUM_UNITS-1:0] EXC_HOT = NUM_UNITS'(1) << EXC_UNIT;

  logic [SPACE_W-1:0]   selSpace;
  logic [NUM_UNITS-1:0] lastHot;

  always_comb begin
    selSpace = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (pushValid[u]) selSpace = selSpace | qSpace[u*SPACE_W +: SPACE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) lastHot <= '0;
    else if (|pushValid) lastHot <= pushValid;
  end

  assert_onehot_push_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pushValid));

  assert_count_match_R11: assert property (@(posedge clk) disable iff (!rstN)
    pushCount == inTaken);

  assert_space_limit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|pushValid) |-> (({{SPACE_W{1'b0}}, pushCount} <= {{CNT_W{1'b0}}, selSpace}) && (pushCount != '0)));

  assert_taken_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    inValid ? (inTaken <= inCount) : (inTaken == '0));

  assert_exc_unit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (excMode && (|pushValid)) |-> (pushValid == EXC_HOT));

  assert_flush_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (pushValid == '0));

  assert_flush_reopens_R9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!(|pushValid) || pushStart));

  assert_same_unit_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((|pushValid) && !pushStart) |-> (pushValid == lastHot));

endmodule

bind braid_distributor braid_distributor_chk #(
  .NUM_UNITS(NUM_UNITS),
  .LANES    (LANES),
  .EXC_UNIT (EXC_UNIT),
  .CNT_W    (CNT_W),
  .SPACE_W  (SPACE_W)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .flush    (flush),
  .excMode  (excMode),
  .inValid  (inValid),
  .inCount  (inCount),
  .inTaken  (inTaken),
  .qSpace   (qSpace),
  .pushValid(pushValid),
  .pushStart(pushStart),
  .pushCount(pushCount)
);

// File: tb/test_braid_distributor.sv
module test_braid_distributor;

  localparam int NU  = 4;
  localparam int LN  = 4;
  localparam int QD  = 8;
  localparam int DW  = 8;
  localparam int EXC = 2;
  localparam int CW  = $clog2(LN + 1);
  localparam int SW  = $clog2(QD + 1);

  logic             clk = 1'b0;
  logic             rstN;
  logic             flush;
  logic             excMode;
  logic             inValid;
  logic [CW-1:0]    inCount;
  logic [LN-1:0]    inStart;
  logic [LN*DW-1:0] inData;
  logic [CW-1:0]    inTaken;
  logic [NU*SW-1:0] qSpace;
  logic [NU-1:0]    unitDone;
  logic [NU-1:0]    pushValid;
  logic             pushStart;
  logic [CW-1:0]    pushCount;
  logic [LN*DW-1:0] pushData;

  int sp [NU];

  always_comb begin
    for (int u = 0; u < NU; u++) qSpace[u*SW +: SW] = SW'(sp[u]);
  end

  always #4 clk = ~clk;

  braid_distributor #(
    .NUM_UNITS(NU), .LANES(LN), .QDEPTH(QD), .DATA_W(DW), .EXC_UNIT(EXC)
  ) i_braid_distributor (
    .clk(clk), .rstN(rstN), .flush(flush), .excMode(excMode),
    .inValid(inValid), .inCount(inCount), .inStart(inStart), .inData(inData),
    .inTaken(inTaken), .qSpace(qSpace), .unitDone(unitDone),
    .pushValid(pushValid), .pushStart(pushStart), .pushCount(pushCount),
    .pushData(pushData)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model state
  bit      mOpen;
  int      mCur;
  bit [NU-1:0] mBusy;
  bit [NU-1:0] mDoneQ;
  int      expUnit;
  int      expTake;
  bit      expStart;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit mIdle(input int u);
    return !mBusy[u] && !(mOpen && mCur == u);
  endfunction

  task automatic modelEval();
    bit es;
    int u;
    int run;
    expUnit = -1; expTake = 0; expStart = 0;
    if (!flush && inValid && inCount > 0) begin
      es = inStart[0] || !mOpen || (excMode && mCur != EXC);
      u = -1;
      if (es) begin
        if (excMode) begin
          if (mIdle(EXC)) u = EXC;
        end else begin
          for (int k = NU - 1; k >= 0; k--) if (mIdle(k)) u = k;
        end
      end else u = mCur;
      if (u >= 0) begin
        run = 1;
        while (run < int'(inCount) && !inStart[run]) run++;
        expTake = (run < sp[u]) ? run : sp[u];
        if (expTake > 0) begin
          expUnit = u;
          expStart = es;
        end
      end
    end
  endtask

  task automatic modelUpdate();
    if (flush) begin
      mOpen = 0; mBusy = '0; mDoneQ = '0; mCur = 0;
    end else begin
      mBusy = mBusy & ~mDoneQ;
      mDoneQ = unitDone;
      if (expUnit >= 0 && expStart) begin
        mBusy[expUnit] = 1'b1;
        mOpen = 1;
        mCur = expUnit;
      end
    end
  endtask

  // called just after a falling edge with inputs already set
  task automatic step(input string tag);
    logic [NU-1:0] ev;
    #2;
    modelEval();
    ev = (expUnit >= 0) ? (NU'(1) << expUnit) : '0;
    chk(pushValid == ev, tag, "pushValid", int'(pushValid), int'(ev));
    chk(int'(inTaken) == expTake, tag, "inTaken", int'(inTaken), expTake);
    if (expUnit >= 0) begin
      chk(pushStart == expStart, tag, "pushStart", int'(pushStart), int'(expStart));
      chk(int'(pushCount) == expTake, "R11", "pushCount", int'(pushCount), expTake);
      chk(pushData == inData, "R11", "pushData", int'(pushData[DW-1:0]), int'(inData[DW-1:0]));
    end
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
  endtask

  task automatic drive(input bit v, input int cnt, input logic [LN-1:0] st);
    inValid = v;
    inCount = CW'(cnt);
    inStart = st;
    for (int i = 0; i < LN; i++) inData[i*DW +: DW] = DW'($urandom);
  endtask

  function automatic bit [31:0] xs(input bit [31:0] s);
    bit [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [31:0] r;
    rstN = 0; flush = 0; excMode = 0; unitDone = '0;
    for (int u = 0; u < NU; u++) sp[u] = QD;
    drive(0, 1, '0);
    mOpen = 0; mCur = 0; mBusy = '0; mDoneQ = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R1 reset state
    drive(0, 1, '0);
    #1;
    chk(pushValid == '0, "R1", "pushValid after reset", int'(pushValid), 0);
    chk(inTaken == '0, "R1", "inTaken after reset", int'(inTaken), 0);
    step("R1");

    // R2 first braid goes to unit 0
    drive(1, 2, 4'b0001);
    #1;
    chk(pushValid == 4'b0001, "R2", "first braid unit", int'(pushValid), 1);
    step("R2");

    // R3 continuation
    drive(1, 3, 4'b0000);
    #1;
    chk(pushValid == 4'b0001 && pushCount == 3, "R3", "continuation count", int'(pushCount), 3);
    step("R3");

    // R4 start at lane 2 truncates
    drive(1, 4, 4'b0100);
    #1;
    chk(inTaken == 2, "R4", "truncated take", int'(inTaken), 2);
    step("R4");

    // R2 next braid lowest idle = unit 1
    drive(1, 2, 4'b0001);
    #1;
    chk(pushValid == 4'b0010, "R2", "second braid unit", int'(pushValid), 2);
    step("R2");

    // R5 zero space stalls, then limited take
    sp[1] = 0;
    drive(1, 2, 4'b0000);
    #1;
    chk(inTaken == 0, "R5", "zero space take", int'(inTaken), 0);
    step("R5");
    sp[1] = 3;
    drive(1, 4, 4'b0000);
    #1;
    chk(inTaken == 3, "R5", "space-limited take", int'(inTaken), 3);
    step("R5");
    sp[1] = QD;

    // R7 release timing of unit 0
    drive(0, 1, '0);
    unitDone = 4'b0001;
    step("R7");
    unitDone = '0;
    drive(1, 1, 4'b0001);
    #1;
    chk(pushValid == 4'b0100, "R7", "unit0 still busy one cycle after done", int'(pushValid), 4);
    step("R7");
    drive(1, 1, 4'b0001);
    #1;
    chk(pushValid == 4'b0001, "R7", "unit0 idle two cycles after done", int'(pushValid), 1);
    step("R7");

    // R6 no idle unit
    drive(1, 1, 4'b0001);
    step("R6");
    drive(1, 2, 4'b0001);
    #1;
    chk(inTaken == 0, "R6", "all units busy", int'(inTaken), 0);
    step("R6");

    // R9 flush, then R10 non-start opens a braid
    flush = 1;
    drive(1, 2, 4'b0001);
    #1;
    chk(pushValid == '0, "R9", "push during flush", int'(pushValid), 0);
    step("R9");
    flush = 0;
    drive(1, 1, 4'b0000);
    #1;
    chk(pushValid == 4'b0001 && pushStart, "R10", "non-start after flush opens unit0", int'(pushValid), 1);
    step("R10");

    // R8 exception mode moves the open braid to unit EXC
    excMode = 1;
    drive(1, 2, 4'b0000);
    #1;
    chk(pushValid == 4'b0100 && pushStart, "R8", "exception redirect", int'(pushValid), 4);
    step("R8");
    drive(1, 1, 4'b0001);
    #1;
    chk(inTaken == 0, "R8", "exception unit occupied", int'(inTaken), 0);
    step("R8");
    excMode = 0;
    flush = 1;
    drive(0, 1, '0);
    step("R9");
    flush = 0;

    // sweep against the model
    r = 32'h1234_5678;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      r = xs(r);
      flush = (r[7:0] == 8'h5a) || cyc == 2000 || cyc == 4000;
      if (cyc == 2000) excMode = 1;
      if (cyc == 4000) excMode = 0;
      drive(r[0] | r[1], 1 + int'(r[3:2]),
            {r[10] & r[11], r[8] & r[9], r[6] & r[7], r[4] & r[5]});
      r = xs(r);
      for (int u = 0; u < NU; u++) begin
        sp[u] = r[u*4] ? QD : int'(r[u*4+1 +: 3]);
        unitDone[u] = (mBusy[u] && r[16+u] && r[20+u]) || (r[24+u] && r[28] && r[29] && r[30]);
      end
      step(excMode ? "R8 sweep" : "R2/R3/R4/R5/R6/R7/R10 sweep");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule